// File: doc/BRIEF.md
# Flow Tuple Hash Unit

This unit turns a 352-bit flow descriptor into the command word that a flow-steering table uses to place or find a filter. The descriptor comes in as eleven 32-bit words. Word 0 holds the flow type, pool and packet-type bits. Words 1 to 10 hold the address, port and flexible-byte fields, already in host order. The same descriptor is hashed twice in parallel, once under a bucket key and once under a signature key, and each hash is 16 bits wide.

The hash is a keyed XOR-fold. The ten field words are first folded into one common word. A high and a low working word are then built from the common word. Word 0 enters these working words asymmetrically: it is mixed into the high word before the key is applied, and into the low word only after key bit 0 has been used. Every set key bit then XORs a right-shifted copy of one of the working words into the result.

The bucket hash is trimmed to the table size picked by a buffer-size selector. In signature mode the upper half of the command word carries the signature hash. In perfect-match mode the upper half carries an index that software assigns to the filter. A result is registered one clock after a valid input and is held until the next one.

Top module: `flow_hash_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first capture, `outValid` is 0 and `cmdWord` is 0.
- R2: `outValid` is high in exactly the cycles that follow a cycle in which `inValid` was sampled high, giving a latency of one clock.
- R3: Descriptor word n sits at `desc[32n+31:32n]`. Words 1 to 10 are XORed together into one common word. The high working word starts as this common word. The low working word is the common word with its two 16-bit halves swapped.
- R4: Word 0 is mixed asymmetrically. The high word is XORed with `w0 ^ (w0 >> 16)` before key bits 0 and 16 are used. The low word is XORed with `w0 ^ (w0 << 16)` only after key bit 0 has been used. As a result, with a key of only bit 0, word 0 has no effect on the hash.
- R5: Key bit 0 XORs the low word into the result, and key bit 16 XORs the high word into it. For each i from 1 to 15, key bit i XORs `low >> i` and key bit i+16 XORs `high >> i`.
- R6: Only the low 16 bits of the accumulated 32-bit result are kept as a hash.
- R7: The bucket field `cmdWord[15:0]` is the bucket hash masked by `bufSel`: 0 keeps 13 bits, 1 keeps 14 bits, 2 keeps 15 bits, and the unused code 3 behaves like 0. The bits above the kept width read 0.
- R8: When `perfectMode` is 0, `cmdWord[31:16]` is the 16-bit signature hash computed under `sigKey`.
- R9: When `perfectMode` is 1, `cmdWord[31:16]` is `softIdx`, and `sigKey` has no effect on the output.
- R10: In a cycle where `inValid` is low, all data inputs are ignored and `cmdWord` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Capture strobe for the descriptor and controls |
| perfectMode | input | 1 | 1: perfect-match packing, 0: signature packing |
| bufSel | input | 2 | Table size: 0 gives 13-bit, 1 gives 14-bit, 2 gives 15-bit bucket, 3 behaves like 0 |
| desc | input | 352 | Eleven descriptor words, word 0 in the least significant bits |
| bucketKey | input | 32 | Key for the bucket hash |
| sigKey | input | 32 | Key for the signature hash |
| softIdx | input | 16 | Software filter index used in perfect-match mode |
| outValid | output | 1 | Result present in `cmdWord` this cycle |
| cmdWord | output | 32 | {signature hash or index, masked bucket hash} |

## Verification
Both `outValid` and `cmdWord` reflect a stimulus one rising edge after it is driven. The bench therefore drives each stimulus on a falling edge. It compares both outputs against its behavioural model on the next falling edge, which is after exactly one capture edge, and it does this on every cycle, idle cycles included. Hand-computed cases are read at that same falling edge. They cover the asymmetric use of word 0, single shifted key bits, the four selector codes, and the ignored signature key and idle inputs.

// File: rtl/fh_pkg.sv
package fh_pkg;

  // Bucket width selection decoded from the buffer-size selector
  typedef enum logic [1:0] {
    BKT_NARROW = 2'd0,
    BKT_MID    = 2'd1,
    BKT_WIDE   = 2'd2
  } fh_width_e;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic      capture;
    logic      usePerfect;
    fh_width_e widthSel;
  } fh_strobe_t;

endpackage

// File: rtl/fh_hash_core.sv
module fh_hash_core #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 11,
  parameter int HASH_W    = 16
) (
  input  logic [WORD_W*NUM_WORDS-1:0] desc,
  input  logic [WORD_W-1:0]           key,
  output logic [HASH_W-1:0]           hash
);

  localparam int HALF = WORD_W / 2;

  logic [WORD_W-1:0] word0;
  logic [WORD_W-1:0] common;
  logic [WORD_W-1:0] hiMix;
  logic [WORD_W-1:0] loPre;
  logic [WORD_W-1:0] loMix;
  logic [WORD_W-1:0] termLo [HALF];
  logic [WORD_W-1:0] termHi [HALF];
  logic [WORD_W-1:0] acc;
  logic              unusedAccHi;

  assign word0 = desc[WORD_W-1:0];

  // Fold the field words together
  always_comb begin
    common = '0;
    for (int w = 1; w < NUM_WORDS; w++) begin
      common = common ^ desc[w*WORD_W +: WORD_W];
    end
  end

  // High word takes word 0 early, low word takes it after key bit 0
  assign hiMix = common ^ word0 ^ (word0 >> HALF);
  assign loPre = {common[HALF-1:0], common[WORD_W-1:HALF]};
  assign loMix = loPre ^ word0 ^ (word0 << HALF);

  for (genvar i = 0; i < HALF; i++) begin : g_term
    if (i == 0) begin : g_first
      assign termLo[i] = key[i] ? loPre : '0;
    end else begin : g_rest
      assign termLo[i] = key[i] ? (loMix >> i) : '0;
    end
    assign termHi[i] = key[i+HALF] ? (hiMix >> i) : '0;
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < HALF; i++) begin
      acc = acc ^ termLo[i] ^ termHi[i];
    end
  end

  assign hash        = acc[HASH_W-1:0];
  assign unusedAccHi = ^acc[WORD_W-1:HASH_W];

endmodule

// File: rtl/fh_control.sv
module fh_control
  import fh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       perfectMode,
  input  logic [1:0] bufSel,
  output fh_strobe_t strb,
  output logic       outValid
);

  fh_width_e widthDec;

  always_comb begin
    case (bufSel)
      2'd1:    widthDec = BKT_MID;
      2'd2:    widthDec = BKT_WIDE;
      default: widthDec = BKT_NARROW;
    endcase
  end

  assign strb.capture    = inValid;
  assign strb.usePerfect = perfectMode;
  assign strb.widthSel   = widthDec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: rtl/fh_datapath.sv
module fh_datapath
  import fh_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int NUM_WORDS   = 11,
  parameter int HASH_W      = 16,
  parameter int BKT_W_SMALL = 13,
  parameter int BKT_W_MID   = 14,
  parameter int BKT_W_LARGE = 15
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  fh_strobe_t                  strb,
  input  logic [WORD_W*NUM_WORDS-1:0] desc,
  input  logic [WORD_W-1:0]           bucketKey,
  input  logic [WORD_W-1:0]           sigKey,
  input  logic [HASH_W-1:0]           softIdx,
  output logic [2*HASH_W-1:0]         cmdWord
);

  localparam int NUM_KEYS = 2;

  function automatic logic [HASH_W-1:0] lowOnes(int n);
    logic [HASH_W-1:0] m;
    m = '0;
    for (int j = 0; j < HASH_W; j++) begin
      if (j < n) m[j] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [HASH_W-1:0] maskOf(fh_width_e w);
    case (w)
      BKT_MID:  return lowOnes(BKT_W_MID);
      BKT_WIDE: return lowOnes(BKT_W_LARGE);
      default:  return lowOnes(BKT_W_SMALL);
    endcase
  endfunction

  logic [WORD_W-1:0] keySet  [NUM_KEYS];
  logic [HASH_W-1:0] hashSet [NUM_KEYS];
  logic [HASH_W-1:0] bucketField;
  logic [HASH_W-1:0] upperField;

  assign keySet[0] = bucketKey;
  assign keySet[1] = sigKey;

  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_core
    fh_hash_core #(
      .WORD_W   (WORD_W),
      .NUM_WORDS(NUM_WORDS),
      .HASH_W   (HASH_W)
    ) u_core (
      .desc(desc),
      .key (keySet[k]),
      .hash(hashSet[k])
    );
  end

  assign bucketField = hashSet[0] & maskOf(strb.widthSel);
  assign upperField  = strb.usePerfect ? softIdx : hashSet[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cmdWord <= '0;
    else if (strb.capture) cmdWord <= {upperField, bucketField};
  end

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.capture) |-> $stable(cmdWord));

  // R7
  bucket_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.capture) |->
      ((cmdWord[HASH_W-1:0] & ~maskOf($past(strb.widthSel))) == '0));

  // R9
  perfect_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.capture) && $past(strb.usePerfect)) |->
      (cmdWord[2*HASH_W-1:HASH_W] == $past(softIdx)));

endmodule

// File: rtl/flow_hash_unit.sv
module flow_hash_unit
  import fh_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int NUM_WORDS   = 11,
  parameter int HASH_W      = 16,
  parameter int BKT_W_SMALL = 13,
  parameter int BKT_W_MID   = 14,
  parameter int BKT_W_LARGE = 15
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        inValid,
  input  logic                        perfectMode,
  input  logic [1:0]                  bufSel,
  input  logic [WORD_W*NUM_WORDS-1:0] desc,
  input  logic [WORD_W-1:0]           bucketKey,
  input  logic [WORD_W-1:0]           sigKey,
  input  logic [HASH_W-1:0]           softIdx,
  output logic                        outValid,
  output logic [2*HASH_W-1:0]         cmdWord
);

  fh_strobe_t strb;

  fh_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .perfectMode(perfectMode),
    .bufSel     (bufSel),
    .strb       (strb),
    .outValid   (outValid)
  );

  fh_datapath #(
    .WORD_W     (WORD_W),
    .NUM_WORDS  (NUM_WORDS),
    .HASH_W     (HASH_W),
    .BKT_W_SMALL(BKT_W_SMALL),
    .BKT_W_MID  (BKT_W_MID),
    .BKT_W_LARGE(BKT_W_LARGE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .desc     (desc),
    .bucketKey(bucketKey),
    .sigKey   (sigKey),
    .softIdx  (softIdx),
    .cmdWord  (cmdWord)
  );

endmodule

// File: tb/sim_flow_hash_unit.sv
`timescale 1ns/1ps
module sim_flow_hash_unit;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic         perfectMode = 1'b0;
  logic [1:0]   bufSel = 2'd0;
  logic [351:0] desc = '0;
  logic [31:0]  bucketKey = '0;
  logic [31:0]  sigKey = '0;
  logic [15:0]  softIdx = '0;
  logic         outValid;
  logic [31:0]  cmdWord;

  int  checks = 0;
  int  fails = 0;
  bit  finished = 0;
  bit  expValid = 0;
  logic [31:0] expCmd = '0;

  always #2.5 clk = ~clk;

  flow_hash_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .perfectMode(perfectMode),
    .bufSel(bufSel), .desc(desc), .bucketKey(bucketKey), .sigKey(sigKey),
    .softIdx(softIdx), .outValid(outValid), .cmdWord(cmdWord)
  );

  // Behavioural hash following R3..R6
  function automatic logic [15:0] refHash(logic [351:0] d, logic [31:0] k);
    logic [31:0] w0, c, hi, lo, r;
    w0 = d[31:0];
    c  = 0;
    for (int n = 1; n < 11; n++) c ^= d[n*32 +: 32];
    hi = c ^ w0 ^ (w0 >> 16);
    lo = {c[15:0], c[31:16]};
    r  = 0;
    if (k[0])  r ^= lo;
    if (k[16]) r ^= hi;
    lo ^= w0 ^ (w0 << 16);
    for (int i = 1; i < 16; i++) begin
      if (k[i])    r ^= lo >> i;
      if (k[i+16]) r ^= hi >> i;
    end
    return r[15:0];
  endfunction

  function automatic logic [15:0] refMask(logic [1:0] s);
    case (s)
      2'd1:    return 16'h3FFF;
      2'd2:    return 16'h7FFF;
      default: return 16'h1FFF;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive on a falling edge, then compare on the next falling edge
  task automatic step(string tag, bit v, bit perf, logic [1:0] sel,
                      logic [351:0] d, logic [31:0] bk, logic [31:0] sk,
                      logic [15:0] idx);
    logic [31:0] nextCmd;
    inValid = v; perfectMode = perf; bufSel = sel; desc = d;
    bucketKey = bk; sigKey = sk; softIdx = idx;
    nextCmd = {perf ? idx : refHash(d, sk), refHash(d, bk) & refMask(sel)};
    @(negedge clk);
    if (v) expCmd = nextCmd;
    expValid = v;
    check({tag, " valid"}, {31'd0, outValid}, {31'd0, expValid});
    check({tag, " cmd"}, cmdWord, expCmd);
  endtask

  function automatic logic [351:0] mkDesc(logic [31:0] w0, logic [31:0] w1);
    logic [351:0] d;
    d = '0;
    d[31:0]  = w0;
    d[63:32] = w1;
    return d;
  endfunction

  function automatic logic [351:0] rndDesc();
    logic [351:0] d;
    for (int w = 0; w < 11; w++) d[w*32 +: 32] = $urandom;
    return d;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [351:0] d;
    logic [31:0]  held;
    repeat (2) @(negedge clk);
    // R1 during and just after reset
    check("R1 reset valid", {31'd0, outValid}, 32'd0);
    check("R1 reset cmd", cmdWord, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 post-reset cmd", cmdWord, 32'd0);

    // R10 / R2 idle with garbage inputs
    step("R10 idle", 0, 0, 2'd2, rndDesc(), $urandom, $urandom, 16'h5555);
    check("R10 idle cmd held zero", cmdWord, 32'd0);

    // R4: key bit 0 only, word 0 must not matter
    step("R4 a", 1, 0, 2'd2, mkDesc(32'hDEADBEEF, 32'h12345678), 32'h1, 32'h1, 0);
    check("R4 word0 ignored a", cmdWord, 32'h12341234);
    step("R4 b", 1, 0, 2'd2, mkDesc(32'h0BADF00D, 32'h12345678), 32'h1, 32'h1, 0);
    check("R4 word0 ignored b", cmdWord, 32'h12341234);
    // R4: key bit 16 sees word0 ^ (word0 >> 16) in the high word
    step("R4 c", 1, 0, 2'd0, mkDesc(32'hDEADBEEF, 32'h12345678), 32'h10000, 32'h10000, 0);
    check("R4 high mix", cmdWord, 32'h363A163A);

    // R5/R6 single shifted key bits, truncated to 16 bits
    step("R5 lo", 1, 0, 2'd2, mkDesc(32'h0, 32'h12345678), 32'h20, 32'h20, 0);
    check("R5 R6 low word shift", cmdWord, 32'hC0914091);
    step("R5 hi", 1, 0, 2'd1, mkDesc(32'h0, 32'h12345678), 32'h200000, 32'h200000, 0);
    check("R5 R6 high word shift", cmdWord, 32'hA2B322B3);

    // R3 fold over later words: same common spread over words 1 and 10
    d = '0; d[63:32] = 32'h12340000; d[351:320] = 32'h00005678;
    step("R3 fold", 1, 0, 2'd2, d, 32'h1, 32'h1, 0);
    check("R3 fold words", cmdWord, 32'h12341234);

    // R7/R8 selector codes
    step("R7 sel0", 1, 0, 2'd0, mkDesc(0, 32'hFFFF0000), 32'h1, 32'h1, 0);
    check("R7 R8 sel0", cmdWord, 32'hFFFF1FFF);
    step("R7 sel1", 1, 0, 2'd1, mkDesc(0, 32'hFFFF0000), 32'h1, 32'h1, 0);
    check("R7 R8 sel1", cmdWord, 32'hFFFF3FFF);
    step("R7 sel2", 1, 0, 2'd2, mkDesc(0, 32'hFFFF0000), 32'h1, 32'h1, 0);
    check("R7 R8 sel2", cmdWord, 32'hFFFF7FFF);
    step("R7 sel3", 1, 0, 2'd3, mkDesc(0, 32'hFFFF0000), 32'h1, 32'h1, 0);
    check("R7 R8 sel3", cmdWord, 32'hFFFF1FFF);

    // R9 perfect mode: index in the top, signature key ignored
    step("R9 a", 1, 1, 2'd0, mkDesc(0, 32'h12345678), 32'h1, 32'hA5A5A5A5, 16'hABCD);
    check("R9 index a", cmdWord, 32'hABCD1234);
    step("R9 b", 1, 1, 2'd0, mkDesc(0, 32'h12345678), 32'h1, 32'h5A5A0F0F, 16'hABCD);
    check("R9 sig key ignored", cmdWord, 32'hABCD1234);

    // R10 inputs ignored while idle
    held = cmdWord;
    step("R10 hold a", 0, 0, 2'd2, rndDesc(), $urandom, $urandom, 16'h1111);
    step("R10 hold b", 0, 1, 2'd1, rndDesc(), $urandom, $urandom, 16'h2222);
    check("R10 held value", cmdWord, held);

    // Mixed random traffic, R2 R3 R5 R8 against the model
    for (int n = 0; n < 300; n++) begin
      step("R2 R3 R5 R8 random", $urandom_range(0, 3) != 0, $urandom_range(0, 1),
           2'($urandom_range(0, 3)), rndDesc(), $urandom, $urandom, 16'($urandom));
    end
    step("R2 drain", 0, 0, 2'd0, '0, 0, 0, 0);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule